// File: doc/BRIEF.md
# Program Counter and Control Register File

This block holds the architectural program counter, an instruction-set-mode flag, a 32-bit status word and a bank of wide control registers. A PC write takes the lowest bit of the incoming value as the new instruction-set mode and stores the address with that bit cleared. The mode flag changes only through a PC write. A direct write attempt on the mode port is dropped and answered with an error pulse.

Control register 0 is not separate storage. It is a window onto the status word. Reads return the status word zero-extended, and writes load the status word from the low half of the data. Six status flags also have their own per-bit write strobes and read outputs, so one flag can change without a full register write. Read data is registered: it appears one cycle after the read index and reflects the state before any write made in the same cycle.

Top module: `pcr_unit`

## Requirements
- R1: When `pc_we` is high at a clock edge, from the next cycle `pc_q` equals `pc_wdata` with bit 0 cleared, and `mode_q` equals `pc_wdata[0]`.
- R2: A write on the mode port (`mode_we`) leaves `mode_q` unchanged. `mode_err` is high in exactly the cycle after each such attempt and low otherwise.
- R3: Writing control register index k (1..63) with `cr_we` stores the full 64-bit value. Presenting k on `cr_ridx` yields that value on `cr_rdata` one cycle later.
- R4: Reading index 0 returns the 32-bit status word in bits 31:0, with bits 63:32 zero.
- R5: Writing index 0 loads `cr_wdata[31:0]` into the status word (`sr_q`) and discards bits 63:32.
- R6: Flag strobe i maps to a status-word bit, with index order 0..5 as follows: 0 → bit 14, 1 → bit 13, 2 → bit 12, 3 → bit 1, 4 → bit 9, 5 → bit 8. When `flag_we[i]` is high, that bit becomes `flag_wdata[i]` and all other status bits keep their values. `flag_q[i]` always shows that bit.
- R7: When a full index-0 write and flag writes occur in the same cycle, the flag values win on their bits and the full write supplies all other bits.
- R8: A synchronous active-high `rst` clears the PC, the mode flag and the status word. After reset, every control register reads as zero, including entries written before the reset.
- R9: A read and a write to the same index in the same cycle return the value held before that write.
- R10: With no index-0 write and no flag strobe, `sr_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | PC write strobe |
| pc_wdata | input | 64 | New PC; bit 0 selects the mode |
| pc_q | output | 64 | Stored PC, bit 0 always zero |
| mode_q | output | 1 | Instruction-set-mode flag |
| mode_we | input | 1 | Direct mode write attempt (ignored) |
| mode_wdata | input | 1 | Data of the ignored mode write |
| mode_err | output | 1 | Pulses one cycle after a mode write attempt |
| cr_we | input | 1 | Control register write strobe |
| cr_widx | input | 6 | Control register write index |
| cr_wdata | input | 64 | Control register write data |
| cr_ridx | input | 6 | Control register read index |
| cr_rdata | output | 64 | Registered read data |
| sr_q | output | 32 | Status word |
| flag_we | input | 6 | Per-flag write strobes |
| flag_wdata | input | 6 | Per-flag write values |
| flag_q | output | 6 | Per-flag current values |

## Verification
The hardest situation to reach is a full index-0 write that collides with flag strobes in the same cycle. The other status bits must then come from the wide write while the strobed bits come from the flag inputs. The bench drives both at once with data whose bit at the strobed position is the opposite of the flag value, so either wrong priority is visible. It also targets two other cases: a read and a write to the same index in the same cycle, and a reset after entries have been filled. The reset case shows that stored data cannot leak through once reset has cleared the bank.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int SR_W  = 32;
  localparam int NFLAG = 6;
  typedef logic [4:0] sr_pos_t;
  // flag strobe index -> status word bit
  localparam sr_pos_t FLAG_POS [NFLAG] = '{5'd14, 5'd13, 5'd12, 5'd1, 5'd9, 5'd8};
endpackage

// File: rtl/pcr_pc_mode.sv
module pcr_pc_mode #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_we,
  input  logic [XLEN-1:0] pc_wdata,
  input  logic            mode_we,
  output logic [XLEN-1:0] pc_q,
  output logic            mode_q,
  output logic            mode_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      mode_q   <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      if (pc_we) begin
        pc_q   <= {pc_wdata[XLEN-1:1], 1'b0};
        mode_q <= pc_wdata[0];
      end
      mode_err <= mode_we;
    end
  end
endmodule

// File: rtl/pcr_status.sv
module pcr_status
  import pcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             full_we,
  input  logic [SR_W-1:0]  full_wdata,
  input  logic [NFLAG-1:0] flag_we,
  input  logic [NFLAG-1:0] flag_wdata,
  output logic [SR_W-1:0]  sr_q,
  output logic [NFLAG-1:0] flag_q
);
  logic [SR_W-1:0] stage [NFLAG+1];

  assign stage[0] = full_we ? full_wdata : sr_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic [SR_W-1:0] mask;
    assign mask         = flag_we[g] ? (SR_W'(1) << FLAG_POS[g]) : '0;
    assign stage[g+1]   = (stage[g] & ~mask) | (flag_wdata[g] ? mask : '0);
    assign flag_q[g]    = sr_q[FLAG_POS[g]];
  end

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= stage[NFLAG];
  end
endmodule

// File: rtl/pcr_cr_bank.sv
module pcr_cr_bank #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [W-1:0]     rd_q;
  logic             vld_q;

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we && !rst) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid[raddr];
      if (we) valid[waddr] <= 1'b1;
    end
  end

  assign rdata = vld_q ? rd_q : '0;
endmodule

// File: rtl/pcr_unit.sv
module pcr_unit
  import pcr_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CR_N  = 64,
  parameter int CR_W  = 64,
  localparam int IW   = $clog2(CR_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pc_we,
  input  logic [XLEN-1:0]  pc_wdata,
  output logic [XLEN-1:0]  pc_q,
  output logic             mode_q,
  input  logic             mode_we,
  input  logic             mode_wdata,
  output logic             mode_err,
  input  logic             cr_we,
  input  logic [IW-1:0]    cr_widx,
  input  logic [CR_W-1:0]  cr_wdata,
  input  logic [IW-1:0]    cr_ridx,
  output logic [CR_W-1:0]  cr_rdata,
  output logic [SR_W-1:0]  sr_q,
  input  logic [NFLAG-1:0] flag_we,
  input  logic [NFLAG-1:0] flag_wdata,
  output logic [NFLAG-1:0] flag_q
);
  logic            sr_full_we, bank_we, sel0_q, unused_mode;
  logic [SR_W-1:0] sr_snap_q;
  logic [CR_W-1:0] bank_rdata;

  assign unused_mode = mode_wdata;
  assign sr_full_we  = cr_we && (cr_widx == '0);
  assign bank_we     = cr_we && (cr_widx != '0);

  pcr_pc_mode #(.XLEN(XLEN)) u_pc (
    .clk(clk), .rst(rst), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .mode_we(mode_we), .pc_q(pc_q), .mode_q(mode_q), .mode_err(mode_err)
  );

  pcr_status u_sr (
    .clk(clk), .rst(rst), .full_we(sr_full_we), .full_wdata(cr_wdata[SR_W-1:0]),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .sr_q(sr_q), .flag_q(flag_q)
  );

  pcr_cr_bank #(.DEPTH(CR_N), .W(CR_W)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .waddr(cr_widx), .wdata(cr_wdata),
    .raddr(cr_ridx), .rdata(bank_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel0_q    <= 1'b0;
      sr_snap_q <= '0;
    end else begin
      sel0_q    <= (cr_ridx == '0);
      sr_snap_q <= sr_q;
    end
  end

  assign cr_rdata = sel0_q ? {{(CR_W-SR_W){1'b0}}, sr_snap_q} : bank_rdata;
endmodule

// File: rtl/pcr_unit_chk.sv
module pcr_unit_chk
  import pcr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CR_W = 64,
  parameter int IW   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             pc_we,
  input logic [XLEN-1:0]  pc_wdata,
  input logic [XLEN-1:0]  pc_q,
  input logic             mode_q,
  input logic             mode_we,
  input logic             mode_err,
  input logic             cr_we,
  input logic [IW-1:0]    cr_widx,
  input logic [CR_W-1:0]  cr_wdata,
  input logic [CR_W-1:0]  cr_rdata,
  input logic [SR_W-1:0]  sr_q,
  input logic [NFLAG-1:0] flag_we,
  input logic [NFLAG-1:0] flag_wdata
);
  a_r1_pc_split: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> (pc_q == {$past(pc_wdata[XLEN-1:1]), 1'b0}) && (mode_q == $past(pc_wdata[0])));

  a_r2_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (mode_we && !pc_we) |=> (mode_q == $past(mode_q)) && mode_err);

  a_r2_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> !mode_err);

  a_r6_fbank_flag: assert property (@(posedge clk) disable iff (rst)
    flag_we[0] |=> sr_q[14] == $past(flag_wdata[0]));

  a_r5_full_low_half: assert property (@(posedge clk) disable iff (rst)
    (cr_we && cr_widx == '0 && flag_we == '0) |=> sr_q == $past(cr_wdata[SR_W-1:0]));

  a_r10_sr_hold: assert property (@(posedge clk) disable iff (rst)
    (!(cr_we && cr_widx == '0) && flag_we == '0) |=> $stable(sr_q));

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (pc_q == '0) && !mode_q && (sr_q == '0) && (cr_rdata == '0));
endmodule

bind pcr_unit pcr_unit_chk #(.XLEN(XLEN), .CR_W(CR_W), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_q),
  .mode_q(mode_q), .mode_we(mode_we), .mode_err(mode_err), .cr_we(cr_we),
  .cr_widx(cr_widx), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .sr_q(sr_q),
  .flag_we(flag_we), .flag_wdata(flag_wdata)
);

// File: tb/pcr_unit_tb.sv
`timescale 1ns/1ps
module pcr_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        pc_we, mode_we, mode_wdata, cr_we;
  logic [63:0] pc_wdata, pc_q, cr_wdata, cr_rdata;
  logic        mode_q, mode_err;
  logic [5:0]  cr_widx, cr_ridx, flag_we, flag_wdata, flag_q;
  logic [31:0] sr_q;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcr_unit u_dut (
    .clk(clk), .rst(rst), .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_q),
    .mode_q(mode_q), .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_err(mode_err),
    .cr_we(cr_we), .cr_widx(cr_widx), .cr_wdata(cr_wdata), .cr_ridx(cr_ridx),
    .cr_rdata(cr_rdata), .sr_q(sr_q), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .flag_q(flag_q)
  );

  // {index, data}
  localparam logic [69:0] VEC [8] = '{
    {6'd1,  64'h0123_4567_89AB_CDEF},
    {6'd63, 64'hFFFF_FFFF_FFFF_FFFF},
    {6'd2,  64'h8000_0000_0000_0001},
    {6'd0,  64'hDEAD_BEEF_CAFE_F00D},
    {6'd17, 64'h5555_AAAA_5555_AAAA},
    {6'd32, 64'h0000_0000_0000_0000},
    {6'd40, 64'hA5A5_0000_0000_5A5A},
    {6'd9,  64'h1111_2222_3333_4444}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pc_we = 0; mode_we = 0; cr_we = 0; flag_we = '0;
  endtask

  task automatic cr_write(logic [5:0] idx, logic [63:0] d);
    cr_we = 1; cr_widx = idx; cr_wdata = d; tick(); cr_we = 0;
  endtask

  task automatic cr_read(logic [5:0] idx);
    cr_ridx = idx; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1; idle(); pc_wdata = '0; mode_wdata = 0; cr_widx = '0; cr_wdata = '0;
    cr_ridx = 6'd5; flag_wdata = '0;
    tick(); tick();
    rst = 0;
    // R8 reset state
    chk("R8 pc", pc_q, 64'h0);
    chk("R8 mode", {63'h0, mode_q}, 64'h0);
    chk("R8 sr", {32'h0, sr_q}, 64'h0);
    chk("R2 err idle", {63'h0, mode_err}, 64'h0);
    cr_read(6'd5);
    chk("R8 cr5", cr_rdata, 64'h0);

    // table: R3/R4/R5
    for (int i = 0; i < 8; i++) cr_write(VEC[i][69:64], VEC[i][63:0]);
    for (int i = 0; i < 8; i++) begin
      logic [63:0] exp;
      exp = (VEC[i][69:64] == 6'd0) ? {32'h0, VEC[i][31:0]} : VEC[i][63:0];
      cr_read(VEC[i][69:64]);
      chk((VEC[i][69:64] == 6'd0) ? "R4 R5 cr0" : "R3 cr", cr_rdata, exp);
    end
    chk("R5 sr low half", {32'h0, sr_q}, 64'h0000_0000_CAFE_F00D);

    // R1 pc write
    pc_we = 1; pc_wdata = 64'h0000_1000_0000_1235; tick(); pc_we = 0;
    chk("R1 pc odd", pc_q, 64'h0000_1000_0000_1234);
    chk("R1 mode set", {63'h0, mode_q}, 64'h1);
    pc_we = 1; pc_wdata = 64'hFFFF_0000_0000_8000; tick(); pc_we = 0;
    chk("R1 pc even", pc_q, 64'hFFFF_0000_0000_8000);
    chk("R1 mode clr", {63'h0, mode_q}, 64'h0);

    // R2 mode port ignored
    mode_we = 1; mode_wdata = 1; tick(); mode_we = 0;
    chk("R2 mode unchanged", {63'h0, mode_q}, 64'h0);
    chk("R2 err pulse", {63'h0, mode_err}, 64'h1);
    tick();
    chk("R2 err drops", {63'h0, mode_err}, 64'h0);

    // R6 single flags
    cr_write(6'd0, 64'h0);
    flag_we = 6'b000001; flag_wdata = 6'b000001; tick(); flag_we = '0;
    chk("R6 fbank bit14", {32'h0, sr_q}, 64'h0000_4000);
    chk("R6 flag_q", {58'h0, flag_q}, 64'h01);
    flag_we = 6'b111111; flag_wdata = 6'b111111; tick(); flag_we = '0;
    chk("R6 all flags", {32'h0, sr_q}, 64'h0000_7302);
    cr_write(6'd0, 64'hFFFF_FFFF);
    flag_we = 6'b100000; flag_wdata = 6'b000000; tick(); flag_we = '0;
    chk("R6 clear divq", {32'h0, sr_q}, 64'hFFFF_FEFF);
    chk("R6 flag_q after clear", {58'h0, flag_q}, 64'h1F);
    tick();
    chk("R10 sr holds", {32'h0, sr_q}, 64'hFFFF_FEFF);

    // R7 collision: full write clears bit1, flag sets it; bit14 set by data, flag clears it
    cr_we = 1; cr_widx = 6'd0; cr_wdata = 64'hAAAA_0000_1234_5678;
    flag_we = 6'b001001; flag_wdata = 6'b001000; tick(); idle();
    chk("R7 flag wins", {32'h0, sr_q}, 64'h1234_167A);

    // R9 read during write
    cr_write(6'd7, 64'hAAAA_BBBB_CCCC_DDDD);
    cr_ridx = 6'd7; cr_we = 1; cr_widx = 6'd7; cr_wdata = 64'h1;
    tick(); cr_we = 0;
    chk("R9 old value", cr_rdata, 64'hAAAA_BBBB_CCCC_DDDD);
    tick();
    chk("R9 new value", cr_rdata, 64'h1);

    // R8 reset after fill
    rst = 1; tick(); rst = 0;
    cr_read(6'd1);
    chk("R8 cr1 cleared", cr_rdata, 64'h0);
    cr_read(6'd0);
    chk("R8 cr0 cleared", cr_rdata, 64'h0);
    chk("R8 pc cleared", pc_q, 64'h0);

    finish_run();
  end
endmodule